// File: doc/BRIEF.md
# DMA engine lifecycle controller

This block is the control state machine of a send DMA engine. It walks the engine through its life: powered down, waiting for the hardware to start, parked idle, running, and back through a halt and clean-up sequence before any restart. Software and hardware report progress as single-cycle event pulses on a one-hot vector. The controller answers in two ways. It drives four engine control bits, which depend only on the current state. It also raises one-cycle requests for the actions that other logic carries out: hardware start-up, hardware clean-up, software clean-up and teardown.

A sticky run-request flag records whether the engine should run once start-up completes. When the hardware reports that it has started, the flag chooses between idle and running. There are two error-halt events. The first goes straight to software clean-up. The second waits for the hardware to halt, then runs hardware clean-up and then software clean-up. A shut-down request can be taken from any state. For debugging, the controller keeps the code of the most recent accepted event and the state it held before its latest transition.

States, with their codes: DOWN (0), STARTUP (1), IDLE (2), SWCLEAN (3), HWCLEAN (4), HALTWAIT (5), RUN (6). Transitions: DOWN→STARTUP, STARTUP→IDLE, STARTUP→RUN, IDLE→RUN, RUN→HALTWAIT, RUN→SWCLEAN, HALTWAIT→HWCLEAN, HWCLEAN→SWCLEAN, SWCLEAN→STARTUP, and every non-DOWN state→DOWN.

Top module: `dma_life_ctl`

## Requirements
- R1: After reset the state code is 0 (DOWN), the run flag is 0, all control bits and action pulses are 0, the last-event code is 15 (none) and the previous-state code is 0.
- R2: Event bits on ev_i: 0 go-down, 1 go-start, 2 hw-started, 3 go-run, 4 sw-cleaned, 5 hw-cleaned, 6 hw-halted, 7 go-idle, 8 error-halt type A, 9 error-halt type B, 10 timer tick. An event is accepted only when exactly one bit is set. A vector with no bits or several bits set changes nothing: state, flag, debug registers and pulses stay as they were.
- R3: In DOWN, go-start moves to STARTUP. Go-run moves to STARTUP and sets the flag. Sw-cleaned pulses teardown and stays in DOWN. Go-down is ignored.
- R4: In STARTUP, hw-started moves to RUN when the flag is 1 and to IDLE when it is 0. Go-down moves to DOWN and pulses teardown.
- R5: In IDLE, go-run moves to RUN and sets the flag. Go-down moves to DOWN and pulses teardown.
- R6: In RUN, go-idle moves to HALTWAIT and clears the flag. Error type A and hw-halted each move to SWCLEAN and pulse software clean-up. Error type B moves to HALTWAIT with no pulse.
- R7: In HALTWAIT, hw-halted moves to HWCLEAN and pulses hardware clean-up.
- R8: In HWCLEAN, hw-cleaned moves to SWCLEAN and pulses software clean-up.
- R9: In SWCLEAN, sw-cleaned moves to STARTUP and pulses hardware start-up. Go-down moves to DOWN with no pulse.
- R10: Go-down in RUN, HALTWAIT or HWCLEAN moves to DOWN and pulses software clean-up.
- R11: In every state, go-run sets the flag and go-idle clears it. The timer tick never changes state or flag. Any event not listed for a state leaves the state unchanged.
- R12: Enable and interrupt-enable are 1 only in RUN. Halt is 1 in HALTWAIT, HWCLEAN and SWCLEAN. Drain is 1 only in HALTWAIT. All four are 0 in every other state.
- R13: An action pulse lasts exactly one cycle. It is high in the first cycle in which the resulting state is visible on state_o, and at most one action pulse is high at a time.
- R14: last_ev_o holds the bit index of the most recently accepted event, including events that cause no transition. prev_state_o holds the state code that was current before the most recent state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | 11 | One-hot event pulses (bit map in R2) |
| state_o | output | 3 | Current state code |
| run_req_o | output | 1 | Sticky run-request flag |
| ctl_enable_o | output | 1 | Engine enable |
| ctl_irq_en_o | output | 1 | Engine interrupt enable |
| ctl_halt_o | output | 1 | Engine halt |
| ctl_drain_o | output | 1 | Engine drain |
| act_hw_start_o | output | 1 | Hardware start-up request pulse |
| act_hw_clean_o | output | 1 | Hardware clean-up request pulse |
| act_sw_clean_o | output | 1 | Software clean-up request pulse |
| act_teardown_o | output | 1 | Teardown request pulse |
| last_ev_o | output | 4 | Code of the last accepted event |
| prev_state_o | output | 3 | State before the latest transition |

## Verification
The assertions check properties that must hold in every cycle. At most one action pulse is high at a time, and each pulse coincides with the state it belongs to. The engine never reaches RUN without the run flag set. Go-down always lands in DOWN, and a timer tick never disturbs state or flag. Halt and enable are never high together. Whether each state's own event table is correct, which way the flag sends STARTUP, and what the debug registers hold can only be shown by the bench, through scenarios that compare every output with a behavioural reference model on every clock.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    localparam int NUM_EV = 11;
    localparam int EV_W   = 4;
    localparam int ST_W   = 3;

    typedef enum logic [ST_W-1:0] {
        ST_DOWN    = 3'd0,
        ST_STARTUP = 3'd1,
        ST_IDLE    = 3'd2,
        ST_SWCLEAN = 3'd3,
        ST_HWCLEAN = 3'd4,
        ST_HALT    = 3'd5,
        ST_RUN     = 3'd6
    } st_e;

    typedef enum logic [EV_W-1:0] {
        EV_GO_DOWN    = 4'd0,
        EV_GO_START   = 4'd1,
        EV_HW_STARTED = 4'd2,
        EV_GO_RUN     = 4'd3,
        EV_SW_CLEANED = 4'd4,
        EV_HW_CLEANED = 4'd5,
        EV_HW_HALTED  = 4'd6,
        EV_GO_IDLE    = 4'd7,
        EV_ERR_A      = 4'd8,
        EV_ERR_B      = 4'd9,
        EV_TICK       = 4'd10,
        EV_NONE       = 4'd15
    } ev_e;

    typedef struct packed {
        logic hw_start;
        logic hw_clean;
        logic sw_clean;
        logic teardown;
    } act_t;

    typedef struct packed {
        logic enable;
        logic irq_en;
        logic halt;
        logic drain;
    } ctl_t;
endpackage

// File: rtl/dlc_ev_decode.sv
module dlc_ev_decode
    import dlc_pkg::*;
#(
    parameter int N = NUM_EV,
    parameter int W = EV_W
) (
    input  logic [N-1:0] ev_vec,
    output logic         ev_valid,
    output ev_e          ev_code
);
    logic [N-1:0][W-1:0] idx_terms;
    logic [W-1:0]        idx_or;

    // each set bit contributes its own index; valid only when one bit is set
    for (genvar g = 0; g < N; g++) begin : g_term
        assign idx_terms[g] = ev_vec[g] ? W'(g) : '0;
    end

    always_comb begin
        idx_or = '0;
        for (int i = 0; i < N; i++) begin
            idx_or = idx_or | idx_terms[i];
        end
    end

    assign ev_valid = $onehot(ev_vec);
    assign ev_code  = ev_valid ? ev_e'(idx_or) : EV_NONE;
endmodule

// File: rtl/dlc_fsm.sv
module dlc_fsm
    import dlc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_valid,
    input  ev_e  ev_code,
    output st_e  state,
    output logic run_flag,
    output act_t act,
    output logic moved,
    output st_e  from_state
);
    st_e  nxt_state;
    logic nxt_flag;
    act_t nxt_act;

    always_comb begin
        nxt_state = state;
        nxt_flag  = run_flag;
        nxt_act   = '0;
        if (ev_valid) begin
            if (ev_code == EV_GO_RUN)  nxt_flag = 1'b1;
            if (ev_code == EV_GO_IDLE) nxt_flag = 1'b0;
            unique case (state)
                ST_DOWN: begin
                    if (ev_code == EV_GO_START || ev_code == EV_GO_RUN) begin
                        nxt_state = ST_STARTUP;
                    end else if (ev_code == EV_SW_CLEANED) begin
                        nxt_act.teardown = 1'b1;
                    end
                end
                ST_STARTUP: begin
                    if (ev_code == EV_HW_STARTED) begin
                        nxt_state = run_flag ? ST_RUN : ST_IDLE;
                    end else if (ev_code == EV_GO_DOWN) begin
                        nxt_state        = ST_DOWN;
                        nxt_act.teardown = 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (ev_code == EV_GO_RUN) begin
                        nxt_state = ST_RUN;
                    end else if (ev_code == EV_GO_DOWN) begin
                        nxt_state        = ST_DOWN;
                        nxt_act.teardown = 1'b1;
                    end
                end
                ST_SWCLEAN: begin
                    if (ev_code == EV_SW_CLEANED) begin
                        nxt_state        = ST_STARTUP;
                        nxt_act.hw_start = 1'b1;
                    end else if (ev_code == EV_GO_DOWN) begin
                        nxt_state = ST_DOWN;
                    end
                end
                ST_HWCLEAN: begin
                    if (ev_code == EV_HW_CLEANED) begin
                        nxt_state        = ST_SWCLEAN;
                        nxt_act.sw_clean = 1'b1;
                    end else if (ev_code == EV_GO_DOWN) begin
                        nxt_state        = ST_DOWN;
                        nxt_act.sw_clean = 1'b1;
                    end
                end
                ST_HALT: begin
                    if (ev_code == EV_HW_HALTED) begin
                        nxt_state        = ST_HWCLEAN;
                        nxt_act.hw_clean = 1'b1;
                    end else if (ev_code == EV_GO_DOWN) begin
                        nxt_state        = ST_DOWN;
                        nxt_act.sw_clean = 1'b1;
                    end
                end
                ST_RUN: begin
                    unique case (ev_code)
                        EV_GO_DOWN: begin
                            nxt_state        = ST_DOWN;
                            nxt_act.sw_clean = 1'b1;
                        end
                        EV_HW_HALTED, EV_ERR_A: begin
                            nxt_state        = ST_SWCLEAN;
                            nxt_act.sw_clean = 1'b1;
                        end
                        EV_GO_IDLE, EV_ERR_B: begin
                            nxt_state = ST_HALT;
                        end
                        default: ;
                    endcase
                end
                default: nxt_state = ST_DOWN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_DOWN;
            run_flag <= 1'b0;
            act      <= '0;
        end else begin
            state    <= nxt_state;
            run_flag <= nxt_flag;
            act      <= nxt_act;
        end
    end

    assign moved      = (nxt_state != state);
    assign from_state = state;
endmodule

// File: rtl/dlc_ctl_decode.sv
module dlc_ctl_decode
    import dlc_pkg::*;
(
    input  st_e  state,
    output ctl_t ctl
);
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_RUN: begin
                ctl.enable = 1'b1;
                ctl.irq_en = 1'b1;
            end
            ST_HALT: begin
                ctl.halt  = 1'b1;
                ctl.drain = 1'b1;
            end
            ST_HWCLEAN, ST_SWCLEAN: ctl.halt = 1'b1;
            ST_DOWN, ST_STARTUP, ST_IDLE: ctl = '0;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/dlc_debug.sv
module dlc_debug
    import dlc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_valid,
    input  ev_e  ev_code,
    input  logic moved,
    input  st_e  from_state,
    output ev_e  last_ev,
    output st_e  prev_state
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_ev    <= EV_NONE;
            prev_state <= ST_DOWN;
        end else begin
            if (ev_valid) last_ev    <= ev_code;
            if (moved)    prev_state <= from_state;
        end
    end
endmodule

// File: rtl/dma_life_ctl.sv
module dma_life_ctl
    import dlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    output logic [ST_W-1:0]   state_o,
    output logic              run_req_o,
    output logic              ctl_enable_o,
    output logic              ctl_irq_en_o,
    output logic              ctl_halt_o,
    output logic              ctl_drain_o,
    output logic              act_hw_start_o,
    output logic              act_hw_clean_o,
    output logic              act_sw_clean_o,
    output logic              act_teardown_o,
    output logic [EV_W-1:0]   last_ev_o,
    output logic [ST_W-1:0]   prev_state_o
);
    logic ev_valid;
    ev_e  ev_code;
    st_e  state;
    logic run_flag;
    act_t act;
    logic moved;
    st_e  from_state;
    ctl_t ctl;
    ev_e  last_ev;
    st_e  prev_state;

    dlc_ev_decode #(.N(NUM_EV), .W(EV_W)) u_dec (
        .ev_vec   (ev_i),
        .ev_valid (ev_valid),
        .ev_code  (ev_code)
    );

    dlc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_code    (ev_code),
        .state      (state),
        .run_flag   (run_flag),
        .act        (act),
        .moved      (moved),
        .from_state (from_state)
    );

    dlc_ctl_decode u_ctl (
        .state (state),
        .ctl   (ctl)
    );

    dlc_debug u_dbg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_code    (ev_code),
        .moved      (moved),
        .from_state (from_state),
        .last_ev    (last_ev),
        .prev_state (prev_state)
    );

    assign state_o        = state;
    assign run_req_o      = run_flag;
    assign ctl_enable_o   = ctl.enable;
    assign ctl_irq_en_o   = ctl.irq_en;
    assign ctl_halt_o     = ctl.halt;
    assign ctl_drain_o    = ctl.drain;
    assign act_hw_start_o = act.hw_start;
    assign act_hw_clean_o = act.hw_clean;
    assign act_sw_clean_o = act.sw_clean;
    assign act_teardown_o = act.teardown;
    assign last_ev_o      = last_ev;
    assign prev_state_o   = prev_state;
endmodule

// File: rtl/dma_life_ctl_chk.sv
module dma_life_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [10:0] ev_i,
    input logic [2:0]  state_o,
    input logic        run_req_o,
    input logic        ctl_enable_o,
    input logic        ctl_halt_o,
    input logic        act_hw_start_o,
    input logic        act_hw_clean_o,
    input logic        act_sw_clean_o,
    input logic        act_teardown_o
);
    p_one_action_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_hw_start_o, act_hw_clean_o, act_sw_clean_o, act_teardown_o}));

    p_teardown_in_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_teardown_o |-> (state_o == 3'd0));

    p_hw_start_in_startup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act_hw_start_o |-> (state_o == 3'd1));

    p_hw_clean_in_hwclean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_hw_clean_o |-> (state_o == 3'd4));

    p_sw_clean_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        act_sw_clean_o |-> (state_o == 3'd3 || state_o == 3'd0));

    p_run_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd6 && $past(state_o) != 3'd6) |-> run_req_o);

    p_go_down_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == 11'h001) |=> (state_o == 3'd0));

    p_tick_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == 11'h400) |=> ($stable(state_o) && $stable(run_req_o)));

    p_halt_not_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_halt_o |-> !ctl_enable_o);
endmodule

bind dma_life_ctl dma_life_ctl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_i           (ev_i),
    .state_o        (state_o),
    .run_req_o      (run_req_o),
    .ctl_enable_o   (ctl_enable_o),
    .ctl_halt_o     (ctl_halt_o),
    .act_hw_start_o (act_hw_start_o),
    .act_hw_clean_o (act_hw_clean_o),
    .act_sw_clean_o (act_sw_clean_o),
    .act_teardown_o (act_teardown_o)
);

// File: tb/dma_life_ctl_tb_top.sv
`timescale 1ns/1ps
module dma_life_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ev = '0;
    logic [2:0]  state_o, prev_state_o;
    logic        run_req_o, en_o, irq_o, halt_o, drain_o;
    logic        a_hs, a_hc, a_sc, a_td;
    logic [3:0]  last_ev_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference model state
    int m_st = 0, m_prev = 0, m_last = 15;
    bit m_flag = 0;
    bit m_hs = 0, m_hc = 0, m_sc = 0, m_td = 0;

    always #5 clk = ~clk;

    dma_life_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .ev_i(ev),
        .state_o(state_o), .run_req_o(run_req_o),
        .ctl_enable_o(en_o), .ctl_irq_en_o(irq_o),
        .ctl_halt_o(halt_o), .ctl_drain_o(drain_o),
        .act_hw_start_o(a_hs), .act_hw_clean_o(a_hc),
        .act_sw_clean_o(a_sc), .act_teardown_o(a_td),
        .last_ev_o(last_ev_o), .prev_state_o(prev_state_o)
    );

    task automatic model_step(input logic [10:0] v);
        int idx, nst;
        m_hs = 0; m_hc = 0; m_sc = 0; m_td = 0;
        if ($countones(v) != 1) return;
        idx = 0;
        for (int i = 0; i < 11; i++) if (v[i]) idx = i;
        m_last = idx;
        nst = m_st;
        if (m_st == 0) begin
            if (idx == 1 || idx == 3) nst = 1;
            else if (idx == 4) m_td = 1;
        end else if (m_st == 1) begin
            if (idx == 2) nst = m_flag ? 6 : 2;
            else if (idx == 0) begin nst = 0; m_td = 1; end
        end else if (m_st == 2) begin
            if (idx == 3) nst = 6;
            else if (idx == 0) begin nst = 0; m_td = 1; end
        end else if (m_st == 3) begin
            if (idx == 4) begin nst = 1; m_hs = 1; end
            else if (idx == 0) nst = 0;
        end else if (m_st == 4) begin
            if (idx == 5) begin nst = 3; m_sc = 1; end
            else if (idx == 0) begin nst = 0; m_sc = 1; end
        end else if (m_st == 5) begin
            if (idx == 6) begin nst = 4; m_hc = 1; end
            else if (idx == 0) begin nst = 0; m_sc = 1; end
        end else if (m_st == 6) begin
            if (idx == 0) begin nst = 0; m_sc = 1; end
            else if (idx == 6 || idx == 8) begin nst = 3; m_sc = 1; end
            else if (idx == 7 || idx == 9) nst = 5;
        end
        if (idx == 3) m_flag = 1;
        if (idx == 7) m_flag = 0;
        if (nst != m_st) begin m_prev = m_st; m_st = nst; end
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "state", int'(state_o), m_st);
        check(tag, "run flag", int'(run_req_o), int'(m_flag));
        check(tag, "actions", int'({a_hs, a_hc, a_sc, a_td}), int'({m_hs, m_hc, m_sc, m_td}));
        check("R12", "ctl bits", int'({en_o, irq_o, halt_o, drain_o}),
              int'({m_st == 6, m_st == 6, (m_st >= 3 && m_st <= 5), m_st == 5}));
        check("R14", "debug", int'({last_ev_o, prev_state_o}), (m_last << 3) | m_prev);
    endtask

    // drive at negedge, model advances at posedge, compare at next negedge
    task automatic step_raw(input logic [10:0] v, input string tag);
        ev = v;
        @(posedge clk);
        model_step(v);
        @(negedge clk);
        ev = '0;
        compare_all(tag);
    endtask

    task automatic step(input int idx, input string tag);
        step_raw(11'(1) << idx, tag);
        step_raw('0, "R13");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // DOWN: ignored events, tick, teardown on sw-cleaned
        step(0, "R3"); step(10, "R11"); step(2, "R11"); step(4, "R3");
        step(7, "R11");
        step(1, "R3");                       // -> STARTUP, flag 0
        step(10, "R11");
        step(2, "R4");                       // -> IDLE
        step(5, "R11"); step(10, "R11");
        step(7, "R11");                      // flag stays 0 in IDLE
        step(3, "R5");                       // -> RUN, flag 1
        step(3, "R11"); step(10, "R11"); step(5, "R11");
        step(8, "R6");                       // err A -> SWCLEAN + sw clean
        step(3, "R11"); step(7, "R11"); step(6, "R11");
        step(4, "R9");                       // -> STARTUP + hw start
        step(3, "R11"); step(7, "R11"); step(3, "R11");
        step(2, "R4");                       // flag 1 -> RUN
        step(7, "R6");                       // -> HALTWAIT, flag 0
        step(10, "R11"); step(3, "R11"); step(5, "R11");
        step(6, "R7");                       // -> HWCLEAN + hw clean
        step(7, "R11"); step(6, "R11");
        step(0, "R10");                      // -> DOWN + sw clean
        step(3, "R3");                       // -> STARTUP, flag 1
        step(0, "R4");                       // teardown
        step(3, "R3"); step(2, "R4");        // RUN
        step(9, "R6");                       // err B -> HALTWAIT no pulse
        step(6, "R7"); step(5, "R8");        // HWCLEAN -> SWCLEAN
        step(0, "R9");                       // -> DOWN no pulse
        step(1, "R3"); step(2, "R4");        // IDLE or RUN depending on flag
        step(0, "R5");
        step(3, "R3"); step(2, "R4");
        step(6, "R6");                       // hw halted in RUN -> SWCLEAN
        step(4, "R9"); step(2, "R4");
        step(0, "R10");                      // go-down from RUN
        step(3, "R3"); step(2, "R4"); step(7, "R6");
        step(0, "R10");                      // go-down from HALTWAIT
        // malformed vectors are ignored
        step(1, "R3"); step(3, "R11");
        step_raw(11'h005, "R2");
        step_raw(11'h7FF, "R2");
        step_raw('0, "R2");
        step(2, "R4");
        step_raw(11'h041, "R2");
        // back-to-back events without gap
        step_raw(11'h080, "R13");
        step_raw(11'h040, "R13");
        step_raw(11'h020, "R13");
        step_raw('0, "R13");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule